// File: doc/BRIEF.md
# Two-Clock FIFO with Selectable Programmable-Flag Timing

This block buffers words between a producer on a write clock and a consumer on a read clock. Storage is an internal register array. Each side keeps its own binary pointer. The pointer crosses to the other clock domain as Gray code through a two-stage synchronizer. The block drives five status outputs, all active-low: empty, full, half-full, almost-empty and almost-full.

The two almost flags compare the fill level against thresholds. Software loads the thresholds through a small write-clock port: a strobe, a select bit and a value. A static strap chooses how the almost flags update:

- **Registered mode:** almost-empty is a flop on the read clock and almost-full is a flop on the write clock. Each behaves like empty and full.
- **Immediate mode:** each almost flag is a combinational compare in the domain where the word count changes. It reacts to the opposite side's pointer without waiting for an edge of its own clock.

Top module: `pflag_fifo`

## Requirements
- R1: Words come out in the order they were accepted. `rd_data` takes the new word on the read edge that accepts the read and holds it otherwise.
- R2: A write while `full_n` is low and a read while `empty_n` is low are ignored. No word is stored, lost or repeated.
- R3: `empty_n` goes low on the read edge that takes the last word. It goes high on the third read edge after the write edge that supplies a word.
- R4: `full_n` goes low on the write edge that stores the DEPTH-th word. It goes high on the third write edge after the read edge that frees a slot.
- R5: `half_n` is low while the write-side word count is DEPTH/2 or more. It uses the same delays as `full_n`.
- R6: A write edge with `thr_we` high loads `thr_val` into the almost-empty threshold when `thr_sel` is 0, and into the almost-full threshold when `thr_sel` is 1. Both thresholds reset to 2.
- R7: With `async_mode` = 0, `aempty_n` is a read-clock register. It is low when (writes seen three edges earlier − reads up to now) ≤ the almost-empty threshold in force before that edge.
- R8: With `async_mode` = 0, `afull_n` is a write-clock register. It is low when DEPTH − (writes up to now − reads seen three edges earlier) ≤ the almost-full threshold in force before that edge.
- R9: With `async_mode` = 1, `aempty_n` follows the write pointer with no read-clock delay. It is low when (writes up to the last write edge − reads two write edges earlier) ≤ the current almost-empty threshold.
- R10: With `async_mode` = 1, `afull_n` follows the read pointer with no write-clock delay. It is low when DEPTH − (writes two read edges earlier − reads up to the last read edge) ≤ the current almost-full threshold.
- R11: During and after reset, `empty_n` and `aempty_n` are low, `full_n`, `half_n` and `afull_n` are high, and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| thr_we | input | 1 | Threshold load strobe (write clock) |
| thr_sel | input | 1 | 0 = almost-empty threshold, 1 = almost-full threshold |
| thr_val | input | ADDR_W+1 | Threshold value |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_en | input | 1 | Read request |
| async_mode | input | 1 | Static strap: 0 registered almost flags, 1 immediate almost flags |
| rd_data | output | DATA_W | Last word read |
| empty_n | output | 1 | Empty, active low |
| full_n | output | 1 | Full, active low |
| half_n | output | 1 | Half full, active low |
| aempty_n | output | 1 | Almost empty, active low |
| afull_n | output | 1 | Almost full, active low |

## Verification
The bench runs both clocks from one source so every delay is a fixed number of edges.

- Pointer movement is visible on the accepting edge: `full_n`, `empty_n` and `rd_data` can change there.
- A pointer reaches the far side two edges later. The registered flags of that side use it on the third edge.
- The immediate-mode flags use the fresh local pointer with no delay, and the far pointer two edges late.

The reference model keeps a four-deep history of accepted write and read totals and forms each expected flag from the history slots that these delays name. It samples every output half a period after each edge. Both strap settings run: full-drain sweeps, overflow and underflow attempts, a threshold change under traffic, and pseudo-random traffic.

// File: rtl/pflag_pkg.sv
package pflag_pkg;

    typedef enum logic {
        THR_LOW  = 1'b0,
        THR_HIGH = 1'b1
    } thr_sel_e;

    typedef enum logic {
        FLAG_REGISTERED = 1'b0,
        FLAG_IMMEDIATE  = 1'b1
    } flag_mode_e;

endpackage

// File: rtl/pflag_gray_sync.sv
module pflag_gray_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = gray_in;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        bin_out[W-1] = s_q.stable[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ s_q.stable[i];
        end
    end
endmodule

// File: rtl/pflag_mem.sv
module pflag_mem #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_fire) cells[wr_addr] <= wr_data;
    end

    assign rd_word = cells[rd_addr];
endmodule

// File: rtl/pflag_wr_ctl.sv
module pflag_wr_ctl
    import pflag_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int AE_RST = 2,
    parameter int AF_RST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              thr_we,
    input  logic              thr_sel,
    input  logic [ADDR_W:0]   thr_val,
    input  logic [ADDR_W:0]   rd_ptr_s,
    output logic              wr_fire,
    output logic [ADDR_W:0]   wr_ptr,
    output logic [ADDR_W:0]   wr_gray,
    output logic              full_n,
    output logic              half_n,
    output logic              afull_reg_n,
    output logic              aempty_imm_n,
    output logic [ADDR_W:0]   ae_thr,
    output logic [ADDR_W:0]   af_thr
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);
    localparam logic [PW-1:0] HALF_P  = PW'(1 << (ADDR_W - 1));

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic          full_n;
        logic          half_n;
        logic          afull_n;
        logic [PW-1:0] ae_thr;
        logic [PW-1:0] af_thr;
    } wr_state_t;

    wr_state_t     s_d, s_q;
    logic          fire;
    logic [PW-1:0] used_nx;
    logic [PW-1:0] used_now;

    always_comb begin
        s_d       = s_q;
        fire      = wr_en && s_q.full_n;
        s_d.ptr   = s_q.ptr + PW'(fire);
        s_d.gray  = s_d.ptr ^ (s_d.ptr >> 1);
        used_nx   = s_d.ptr - rd_ptr_s;
        s_d.full_n  = (used_nx != DEPTH_P);
        s_d.half_n  = !(used_nx >= HALF_P);
        s_d.afull_n = !((DEPTH_P - used_nx) <= s_q.af_thr);
        if (thr_we) begin
            if (thr_sel_e'(thr_sel) == THR_LOW) s_d.ae_thr = thr_val;
            else                                s_d.af_thr = thr_val;
        end
        used_now     = s_q.ptr - rd_ptr_s;
        aempty_imm_n = !(used_now <= s_q.ae_thr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.full_n  <= 1'b1;
            s_q.half_n  <= 1'b1;
            s_q.afull_n <= 1'b1;
            s_q.ae_thr  <= PW'(AE_RST);
            s_q.af_thr  <= PW'(AF_RST);
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_fire     = fire;
    assign wr_ptr      = s_q.ptr;
    assign wr_gray     = s_q.gray;
    assign full_n      = s_q.full_n;
    assign half_n      = s_q.half_n;
    assign afull_reg_n = s_q.afull_n;
    assign ae_thr      = s_q.ae_thr;
    assign af_thr      = s_q.af_thr;
endmodule

// File: rtl/pflag_rd_ctl.sv
module pflag_rd_ctl #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wr_ptr_s,
    input  logic [ADDR_W:0]   ae_thr,
    input  logic [ADDR_W:0]   af_thr,
    input  logic [DATA_W-1:0] mem_word,
    output logic [ADDR_W:0]   rd_ptr,
    output logic [ADDR_W:0]   rd_gray,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              aempty_reg_n,
    output logic              afull_imm_n
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

    typedef struct packed {
        logic [PW-1:0]     ptr;
        logic [PW-1:0]     gray;
        logic [DATA_W-1:0] data;
        logic              empty_n;
        logic              aempty_n;
    } rd_state_t;

    rd_state_t     s_d, s_q;
    logic          fire;
    logic [PW-1:0] used_nx;
    logic [PW-1:0] used_now;

    always_comb begin
        s_d          = s_q;
        fire         = rd_en && s_q.empty_n;
        s_d.ptr      = s_q.ptr + PW'(fire);
        s_d.gray     = s_d.ptr ^ (s_d.ptr >> 1);
        if (fire) s_d.data = mem_word;
        used_nx      = wr_ptr_s - s_d.ptr;
        s_d.empty_n  = (used_nx != '0);
        s_d.aempty_n = !(used_nx <= ae_thr);
        used_now     = wr_ptr_s - s_q.ptr;
        afull_imm_n  = !((DEPTH_P - used_now) <= af_thr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_ptr       = s_q.ptr;
    assign rd_gray      = s_q.gray;
    assign rd_data      = s_q.data;
    assign empty_n      = s_q.empty_n;
    assign aempty_reg_n = s_q.aempty_n;
endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo
    import pflag_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 4,
    parameter int AE_RST = 2,
    parameter int AF_RST = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              thr_we,
    input  logic              thr_sel,
    input  logic [ADDR_W:0]   thr_val,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    input  logic              async_mode,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              full_n,
    output logic              half_n,
    output logic              aempty_n,
    output logic              afull_n
);
    localparam int PW = ADDR_W + 1;

    logic          wr_fire;
    logic [PW-1:0] wr_ptr, wr_gray, rd_ptr, rd_gray;
    logic [PW-1:0] wr_ptr_at_rd, rd_ptr_at_wr;
    logic [PW-1:0] ae_thr, af_thr;
    logic          afull_reg_n, aempty_imm_n, aempty_reg_n, afull_imm_n;
    logic [DATA_W-1:0] mem_word;

    pflag_wr_ctl #(.ADDR_W(ADDR_W), .AE_RST(AE_RST), .AF_RST(AF_RST)) i_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en),
        .thr_we(thr_we), .thr_sel(thr_sel), .thr_val(thr_val),
        .rd_ptr_s(rd_ptr_at_wr), .wr_fire(wr_fire), .wr_ptr(wr_ptr),
        .wr_gray(wr_gray), .full_n(full_n), .half_n(half_n),
        .afull_reg_n(afull_reg_n), .aempty_imm_n(aempty_imm_n),
        .ae_thr(ae_thr), .af_thr(af_thr)
    );

    pflag_gray_sync #(.W(PW)) i_rd2wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .gray_in(rd_gray), .bin_out(rd_ptr_at_wr)
    );

    pflag_gray_sync #(.W(PW)) i_wr2rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .gray_in(wr_gray), .bin_out(wr_ptr_at_rd)
    );

    pflag_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mem (
        .wr_clk(wr_clk), .wr_fire(wr_fire), .wr_addr(wr_ptr[ADDR_W-1:0]),
        .wr_data(wr_data), .rd_addr(rd_ptr[ADDR_W-1:0]), .rd_word(mem_word)
    );

    pflag_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en),
        .wr_ptr_s(wr_ptr_at_rd), .ae_thr(ae_thr), .af_thr(af_thr),
        .mem_word(mem_word), .rd_ptr(rd_ptr), .rd_gray(rd_gray),
        .rd_data(rd_data), .empty_n(empty_n),
        .aempty_reg_n(aempty_reg_n), .afull_imm_n(afull_imm_n)
    );

    assign aempty_n = (flag_mode_e'(async_mode) == FLAG_IMMEDIATE) ? aempty_imm_n : aempty_reg_n;
    assign afull_n  = (flag_mode_e'(async_mode) == FLAG_IMMEDIATE) ? afull_imm_n  : afull_reg_n;
endmodule

// File: rtl/pflag_fifo_chk.sv
module pflag_fifo_chk #(
    parameter int ADDR_W = 4
) (
    input logic            wr_clk,
    input logic            rd_clk,
    input logic            wr_rst_n,
    input logic            rd_rst_n,
    input logic            wr_en,
    input logic            rd_en,
    input logic            async_mode,
    input logic            empty_n,
    input logic            full_n,
    input logic            half_n,
    input logic            aempty_n,
    input logic            afull_n,
    input logic [ADDR_W:0] wr_ptr,
    input logic [ADDR_W:0] rd_ptr,
    input logic [ADDR_W:0] wr_gray
);
    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && !full_n) |=> (wr_ptr == $past(wr_ptr))); // R2

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && !empty_n) |=> (rd_ptr == $past(rd_ptr))); // R2

    AST_EMPTY_FULL_EXCL: assert property (@(posedge wr_clk) disable iff (!wr_rst_n || !rd_rst_n)
        !(!empty_n && !full_n)); // R3

    AST_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $onehot0(wr_gray ^ $past(wr_gray))); // R4

    AST_FULL_IS_HALF: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !full_n |-> !half_n); // R5

    AST_EMPTY_IS_AE: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!async_mode && !empty_n) |-> !aempty_n); // R7

    AST_FULL_IS_AF: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (!async_mode && !full_n) |-> !afull_n); // R8
endmodule

bind pflag_fifo pflag_fifo_chk #(.ADDR_W(ADDR_W)) i_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n(wr_rst_n), .rd_rst_n(rd_rst_n),
    .wr_en(wr_en), .rd_en(rd_en), .async_mode(async_mode),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n),
    .aempty_n(aempty_n), .afull_n(afull_n),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .wr_gray(wr_gray)
);

// File: tb/test_pflag_fifo.sv
module test_pflag_fifo;
    localparam int DATA_W = 9;
    localparam int ADDR_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, thr_we = 1'b0, thr_sel = 1'b0, async_mode = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ADDR_W:0]   thr_val = '0;
    logic [DATA_W-1:0] rd_data;
    logic empty_n, full_n, half_n, aempty_n, afull_n;

    always #4 clk = ~clk;

    pflag_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_pflag_fifo (
        .wr_clk(clk), .wr_rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .thr_we(thr_we), .thr_sel(thr_sel), .thr_val(thr_val),
        .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(rd_en), .async_mode(async_mode),
        .rd_data(rd_data), .empty_n(empty_n), .full_n(full_n), .half_n(half_n),
        .aempty_n(aempty_n), .afull_n(afull_n)
    );

    int n_cmp = 0, n_bad = 0;
    int wh [4];
    int rh [4];
    int ae_now, ae_prev, af_now, af_prev;
    logic x_empty_n, x_full_n, x_half_n, x_ae_n, x_af_n;
    logic [DATA_W-1:0] x_data;
    logic [DATA_W-1:0] q [$];
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input logic act, input logic exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin wh[i] = 0; rh[i] = 0; end
        ae_now = 2; ae_prev = 2; af_now = 2; af_prev = 2;
        q.delete();
        x_data = '0;
        x_empty_n = 1'b0; x_full_n = 1'b1; x_half_n = 1'b1; x_ae_n = 1'b0; x_af_n = 1'b1;
    endtask

    task automatic compare_all();
        chk(empty_n, x_empty_n, "R3 empty_n");
        chk(full_n, x_full_n, "R4 full_n");
        chk(half_n, x_half_n, "R5 half_n");
        chk(aempty_n, x_ae_n, async_mode ? "R9 aempty_n" : "R7 aempty_n");
        chk(afull_n, x_af_n, async_mode ? "R10 afull_n" : "R8 afull_n");
        n_cmp++;
        if (rd_data !== x_data) begin
            n_bad++;
            $display("FAIL R1 rd_data at %0t: actual %0h expected %0h", $time, rd_data, x_data);
        end
    endtask

    // One clock: inputs are already stable; update the model at the edge, compare mid-cycle.
    task automatic tick();
        logic wa, ra;
        @(posedge clk);
        if (!rst_n) begin
            model_reset();
        end else begin
            wa = wr_en && x_full_n;   // R2: refused when full
            ra = rd_en && x_empty_n;  // R2: refused when empty
            for (int i = 3; i > 0; i--) begin wh[i] = wh[i-1]; rh[i] = rh[i-1]; end
            wh[0] += int'(wa);
            rh[0] += int'(ra);
            if (wa) q.push_back(wr_data);
            if (ra) x_data = q.pop_front();
            ae_prev = ae_now; af_prev = af_now;
            if (thr_we) begin  // R6
                if (thr_sel) af_now = int'(thr_val);
                else         ae_now = int'(thr_val);
            end
            x_empty_n = (wh[3] - rh[0]) != 0;
            x_full_n  = (wh[0] - rh[3]) != DEPTH;
            x_half_n  = !((wh[0] - rh[3]) >= DEPTH / 2);
            if (async_mode) begin
                x_ae_n = !((wh[0] - rh[2]) <= ae_now);
                x_af_n = !((DEPTH - (wh[2] - rh[0])) <= af_now);
            end else begin
                x_ae_n = !((wh[3] - rh[0]) <= ae_prev);
                x_af_n = !((DEPTH - (wh[0] - rh[3])) <= af_prev);
            end
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic cycle(input logic w, input logic r);
        wr_en = w; rd_en = r;
        if (w) wr_data = wr_data + 1'b1;
        tick();
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic run_phase(input logic mode);
        rst_n = 1'b0;
        async_mode = mode;
        repeat (3) tick();           // R11: reset values checked each tick
        rst_n = 1'b1;
        tick();
        // R4/R2: fill past full
        for (int i = 0; i < DEPTH + 3; i++) cycle(1'b1, 1'b0);
        repeat (4) cycle(1'b0, 1'b0);
        // R3/R2: drain past empty, R1 order
        for (int i = 0; i < DEPTH + 3; i++) cycle(1'b0, 1'b1);
        repeat (4) cycle(1'b0, 1'b0);
        // R6: new thresholds while idle
        thr_we = 1'b1; thr_sel = 1'b0; thr_val = 5'd5; tick();
        thr_sel = 1'b1; thr_val = 5'd3; tick();
        thr_we = 1'b0;
        // R9/R7: single writes spaced apart to observe the almost-empty delay
        for (int i = 0; i < 8; i++) begin cycle(1'b1, 1'b0); repeat (3) cycle(1'b0, 1'b0); end
        // pseudo-random traffic with a threshold change in the middle
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i == 200) begin thr_we = 1'b1; thr_sel = 1'b1; thr_val = 5'd6; end
            else thr_we = 1'b0;
            cycle(lfsr[0] | lfsr[5], lfsr[2] & ~(i < 100 ? lfsr[7] : 1'b0));
        end
        thr_we = 1'b0;
        // R10/R8: fill, then single reads spaced apart
        for (int i = 0; i < DEPTH; i++) cycle(1'b1, 1'b0);
        repeat (4) cycle(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin cycle(1'b0, 1'b1); repeat (3) cycle(1'b0, 1'b0); end
        // simultaneous traffic then drain
        for (int i = 0; i < 30; i++) cycle(1'b1, 1'b1);
        for (int i = 0; i < DEPTH + 4; i++) cycle(1'b0, 1'b1);
        repeat (4) cycle(1'b0, 1'b0);
    endtask

    bit done = 1'b0;

    initial begin
        model_reset();
        @(negedge clk);
        run_phase(1'b0);
        run_phase(1'b1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule